// File: doc/BRIEF.md
# Packet Whitening and CRC Framer

This block sits on a byte stream between a packet store and a radio FIFO. It accepts bytes through a valid/ready handshake and works in one of two directions, picked per frame. Going out, it scrambles each payload byte with a fixed key chosen by the byte's position, runs a 16-bit checksum over the scrambled bytes, and appends that checksum, masked by a constant, as two trailing bytes. Coming in, it runs the checksum over the bytes as received, descrambles the payload for its output, and compares the masked checksum against the two trailing bytes to give a pass or fail verdict.

A marker on the first byte restarts the frame. A marker on the final byte closes it. The frame length is fixed for each direction. Any frame that ends at the wrong position is reported as a failure. The output side has no back-pressure: each output byte is valid for exactly one cycle.

Top module: `wcrc_framer`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid`, `out_last`, `crc_ok_valid` and `crc_ok` are 0.
- R2: In transmit (`dir_rx`=0), a byte accepted at position i appears on `out_data` in the next cycle as the input XOR key k(i). The keys, by position, are k0=80h, k1=44h, k2=64h, k3=75h, k4=6Ch, k5=71h, k6=2Ah, k7=36h, k8=7Ch, k9=F1h, k10=6Eh, k11=52h, k12=09h and k13=9Dh.
- R3: The checksum is CRC-16 with polynomial 0x1021, fed MSB first, with no reflection. It starts from zero at position 0 of every frame. In transmit it is fed the keyed byte.
- R4: A transmit frame of 14 bytes, with `in_last` on position 13, is followed by the checksum XOR 0x60DE: the high byte in the next cycle, then the low byte with `out_last`=1. `in_ready` is 0 for those two cycles. `crc_ok_valid`=1 and `crc_ok`=1 appear together with the low byte.
- R5: In receive (`dir_rx`=1), positions 0 to 10 are output XOR their keys in the cycle after acceptance, with `out_last` on position 10. Positions 11 and 12 never reach the output.
- R6: In receive, the checksum is fed the raw bytes at positions 0 to 10. Position 11 must equal the high byte of checksum XOR 0xA950, and position 12 its low byte. `crc_ok_valid` pulses in the cycle after position 12 is accepted, with `crc_ok`=1 when both bytes match.
- R7: In receive, a mismatch in either trailing byte, or any altered payload byte, gives `crc_ok`=0 with `crc_ok_valid`=1.
- R8: A frame ends on a byte with `in_last`, or on the final position (13 for transmit, 12 for receive), whichever comes first. If both do not hold together, `crc_ok_valid` pulses with `crc_ok`=0. A wrong-length transmit frame gets no checksum bytes, and its ending byte carries `out_last`.
- R9: A byte with `in_first` is position 0. It abandons any partial frame without a verdict and restarts the checksum. The direction is taken from `dir_rx` on the position-0 byte and held for the rest of the frame.
- R10: A byte offered while `in_ready` is 0 is neither consumed nor output. It is taken once `in_ready` returns.
- R11: `crc_ok` is 0 whenever `crc_ok_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_rx | input | 1 | Direction for the frame: 0 transmit, 1 receive |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take a byte |
| in_data | input | 8 | Input byte |
| in_first | input | 1 | Byte is position 0 of a frame |
| in_last | input | 1 | Byte ends the frame |
| out_valid | output | 1 | Output byte valid (one cycle) |
| out_data | output | 8 | Keyed payload or checksum byte |
| out_last | output | 1 | Final output byte of the frame |
| crc_ok_valid | output | 1 | Verdict strobe |
| crc_ok | output | 1 | Verdict: 1 pass, 0 fail |

## Verification
A wrong position count shows up within one byte: the next output byte is keyed with the wrong key, and the trailer or verdict lands a frame position early or late. A corrupted checksum register stays hidden until the end of the frame. In transmit it then appears in the two appended bytes, and in receive as a false verdict, so every frame is compared byte by byte along with its verdict. Stale direction or match state carried between frames shows up on the next frame that is restarted or back-to-back.

// File: rtl/wcrc_pkg.sv
package wcrc_pkg;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned CRC_W    = 16;
  localparam int unsigned TX_PAY_D = 14;
  localparam int unsigned RX_PAY_D = 11;

  localparam logic [CRC_W-1:0] CRC_POLY  = 16'h1021;
  localparam logic [CRC_W-1:0] TX_MASK_D = 16'h60DE;
  localparam logic [CRC_W-1:0] RX_MASK_D = 16'hA950;

  typedef enum logic [1:0] {
    ST_DATA,
    ST_HI,
    ST_LO
  } fr_state_e;

  // One byte through the checksum, MSB first, no reflection.
  function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c,
                                                input logic [BYTE_W-1:0] b);
    logic [CRC_W-1:0] r;
    r = c ^ {b, {(CRC_W-BYTE_W){1'b0}}};
    for (int i = 0; i < BYTE_W; i++) begin
      r = r[CRC_W-1] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/wcrc_key_rom.sv
module wcrc_key_rom #(
  parameter int unsigned POS_W = 4
) (
  input  logic [POS_W-1:0] pos,
  output logic [7:0]       key
);

  always_comb begin
    case (int'(pos))
      0:       key = 8'h80;
      1:       key = 8'h44;
      2:       key = 8'h64;
      3:       key = 8'h75;
      4:       key = 8'h6C;
      5:       key = 8'h71;
      6:       key = 8'h2A;
      7:       key = 8'h36;
      8:       key = 8'h7C;
      9:       key = 8'hF1;
      10:      key = 8'h6E;
      11:      key = 8'h52;
      12:      key = 8'h09;
      13:      key = 8'h9D;
      default: key = 8'h00;
    endcase
  end

endmodule

// File: rtl/wcrc_crc16.sv
module wcrc_crc16 import wcrc_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic              start,
  input  logic [BYTE_W-1:0] din,
  output logic [CRC_W-1:0]  crc_q
);

  logic [CRC_W-1:0] crc_d;

  always_comb begin
    crc_d = crc_byte(start ? '0 : crc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '0;
    end else if (upd) begin
      crc_q <= crc_d;
    end
  end

  AST_CRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(crc_q)); // R3

endmodule

// File: rtl/wcrc_framer.sv
module wcrc_framer import wcrc_pkg::*; #(
  parameter int unsigned      TX_PAY  = TX_PAY_D,
  parameter int unsigned      RX_PAY  = RX_PAY_D,
  parameter logic [CRC_W-1:0] TX_MASK = TX_MASK_D,
  parameter logic [CRC_W-1:0] RX_MASK = RX_MASK_D
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dir_rx,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_first,
  input  logic       in_last,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_last,
  output logic       crc_ok_valid,
  output logic       crc_ok
);

  localparam int unsigned MAX_POS = (TX_PAY > RX_PAY + 2) ? TX_PAY : RX_PAY + 2;
  localparam int unsigned POS_W   = $clog2(MAX_POS);
  localparam logic [POS_W-1:0] TX_END   = POS_W'(TX_PAY - 1);
  localparam logic [POS_W-1:0] RX_END   = POS_W'(RX_PAY + 1);
  localparam logic [POS_W-1:0] RX_HI    = POS_W'(RX_PAY);
  localparam logic [POS_W-1:0] RX_LPAY  = POS_W'(RX_PAY - 1);
  localparam logic [POS_W-1:0] POS_TOP  = POS_W'(MAX_POS - 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  fr_state_e        st_q, st_d;
  logic [POS_W-1:0] pos_q, pos_d, pos_now, end_pos;
  logic             dir_q, dir_d, hi_ok_q, hi_ok_d;
  logic             is_rx, acc, at_end, len_ok;
  logic [7:0]       key, white, crc_din;
  logic [CRC_W-1:0] crc_q, fin_tx, fin_rx;
  logic             crc_upd, crc_start;
  logic             ov_d, ol_d, rep_d, ok_d;
  logic [7:0]       od_d;

  wcrc_key_rom #(.POS_W(POS_W)) u_key (
    .pos (pos_now),
    .key (key)
  );

  wcrc_crc16 u_crc (
    .clk   (clk),
    .rst_n (rst_sn),
    .upd   (crc_upd),
    .start (crc_start),
    .din   (crc_din),
    .crc_q (crc_q)
  );

  always_comb begin
    in_ready  = (st_q == ST_DATA);
    acc       = in_valid & in_ready;
    pos_now   = in_first ? '0 : pos_q;
    is_rx     = (pos_now == '0) ? dir_rx : dir_q;
    end_pos   = is_rx ? RX_END : TX_END;
    at_end    = acc & (in_last | (pos_now == end_pos));
    len_ok    = in_last & (pos_now == end_pos);
    white     = in_data ^ key;
    fin_tx    = crc_q ^ TX_MASK;
    fin_rx    = crc_q ^ RX_MASK;
    crc_start = (pos_now == '0);
    crc_din   = is_rx ? in_data : white;
    crc_upd   = acc & (~is_rx | (pos_now < RX_HI));
  end

  // next-state and output decode
  always_comb begin
    st_d    = st_q;
    pos_d   = pos_q;
    dir_d   = dir_q;
    hi_ok_d = hi_ok_q;
    ov_d    = 1'b0;
    od_d    = white;
    ol_d    = 1'b0;
    rep_d   = 1'b0;
    ok_d    = 1'b0;
    case (st_q)
      ST_DATA: begin
        if (acc) begin
          dir_d = is_rx;
          pos_d = at_end ? '0 : pos_now + POS_W'(1);
          if (is_rx) begin
            ov_d = (pos_now < RX_HI);
            ol_d = (pos_now == RX_LPAY);
            if (pos_now == RX_HI) hi_ok_d = (in_data == fin_rx[15:8]);
            if (at_end) begin
              rep_d = 1'b1;
              ok_d  = len_ok & hi_ok_q & (in_data == fin_rx[7:0]);
            end
          end else begin
            ov_d = 1'b1;
            if (at_end) begin
              if (len_ok) begin
                st_d = ST_HI;
              end else begin
                ol_d  = 1'b1;
                rep_d = 1'b1;
              end
            end
          end
        end
      end
      ST_HI: begin
        ov_d = 1'b1;
        od_d = fin_tx[15:8];
        st_d = ST_LO;
      end
      ST_LO: begin
        ov_d  = 1'b1;
        od_d  = fin_tx[7:0];
        ol_d  = 1'b1;
        rep_d = 1'b1;
        ok_d  = 1'b1;
        st_d  = ST_DATA;
      end
      default: st_d = ST_DATA;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q         <= ST_DATA;
      pos_q        <= '0;
      dir_q        <= 1'b0;
      hi_ok_q      <= 1'b0;
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_last     <= 1'b0;
      crc_ok_valid <= 1'b0;
      crc_ok       <= 1'b0;
    end else begin
      st_q <= st_d;
      if (acc) begin
        pos_q   <= pos_d;
        dir_q   <= dir_d;
        hi_ok_q <= hi_ok_d;
      end
      if (ov_d) out_data <= od_d;
      out_valid    <= ov_d;
      out_last     <= ol_d;
      crc_ok_valid <= rep_d;
      crc_ok       <= ok_d;
    end
  end

  AST_OK_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_sn)
    crc_ok |-> crc_ok_valid); // R11
  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_sn)
    out_last |-> out_valid); // R4
  AST_TRAILER_STALL: assert property (@(posedge clk) disable iff (!rst_sn)
    (acc && at_end && !is_rx && len_ok) |=> (!in_ready ##1 !in_ready)); // R4
  AST_RX_TRAILER_HIDDEN: assert property (@(posedge clk) disable iff (!rst_sn)
    (acc && is_rx && pos_now >= RX_HI) |=> !out_valid); // R5
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_sn)
    pos_q <= POS_TOP); // R8

endmodule

// File: tb/wcrc_framer_bench.sv
module wcrc_framer_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       dir_rx, in_valid, in_first, in_last;
  logic [7:0] in_data;
  logic       in_ready, out_valid, out_last, crc_ok_valid, crc_ok;
  logic [7:0] out_data;

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0] obuf [0:63];
  bit         olast[0:63];
  int         ocnt;
  bit         okv  [0:7];
  int         okcnt;
  bit         stray_ok;

  always #5 clk = ~clk;

  wcrc_framer u_wcrc_framer (
    .clk(clk), .rst_n(rst_n), .dir_rx(dir_rx), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_first(in_first),
    .in_last(in_last), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .crc_ok_valid(crc_ok_valid), .crc_ok(crc_ok)
  );

  function automatic logic [7:0] kv(input int i);
    case (i)
      0: return 8'h80;  1: return 8'h44;  2: return 8'h64;  3: return 8'h75;
      4: return 8'h6C;  5: return 8'h71;  6: return 8'h2A;  7: return 8'h36;
      8: return 8'h7C;  9: return 8'hF1; 10: return 8'h6E; 11: return 8'h52;
      12: return 8'h09; 13: return 8'h9D;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [15:0] crc_add(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int b = 7; b >= 0; b--) begin
      logic fb = r[15] ^ d[b];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  // collector, sampled away from the active edge
  always @(negedge clk) begin
    if (out_valid && ocnt < 64) begin
      obuf[ocnt]  = out_data;
      olast[ocnt] = out_last;
      ocnt++;
    end
    if (crc_ok_valid && okcnt < 8) begin
      okv[okcnt] = crc_ok;
      okcnt++;
    end
    if (crc_ok && !crc_ok_valid) stray_ok = 1'b1;
  end

  task automatic chk(input bit c, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!c) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clr();
    ocnt = 0; okcnt = 0;
  endtask

  task automatic put(input logic [7:0] d, input bit f, input bit l);
    in_data = d; in_first = f; in_last = l; in_valid = 1'b1;
    while (in_ready !== 1'b1) @(negedge clk);
    @(negedge clk);
  endtask

  // corrupt: 0 none, 1 trailer high, 2 trailer low, 3 payload byte
  task automatic run_frame(input bit rx, input int n, input bit use_last,
                           input int corrupt, input bit flip_dir,
                           input bit junk, input string tag);
    logic [7:0] src[0:15];
    logic [7:0] expo[0:19];
    bit         expl[0:19];
    int         en, e_ok;
    logic [15:0] c;
    bit         good;
    c = 16'h0000;
    en = 0;
    for (int i = 0; i < 20; i++) expl[i] = 1'b0;
    if (!rx) begin
      good = (n == 14) && use_last;
      for (int i = 0; i < n; i++) begin
        src[i] = 8'($urandom_range(0, 255));
        expo[en] = src[i] ^ kv(i); en++;
        c = crc_add(c, src[i] ^ kv(i));
      end
      c = c ^ 16'h60DE;
      if (good) begin
        expo[en] = c[15:8]; en++;
        expo[en] = c[7:0];  en++;
      end
      expl[en-1] = 1'b1;
      e_ok = good;
    end else begin
      logic [7:0] pl[0:10];
      for (int i = 0; i < 11; i++) begin
        pl[i]  = 8'($urandom_range(0, 255));
        src[i] = pl[i] ^ kv(i);
        c = crc_add(c, src[i]);
      end
      c = c ^ 16'hA950;
      src[11] = c[15:8];
      src[12] = c[7:0];
      if (corrupt == 1) src[11] = src[11] ^ 8'h10;
      if (corrupt == 2) src[12] = src[12] ^ 8'h01;
      if (corrupt == 3) src[4]  = src[4]  ^ 8'h80;
      for (int i = 0; i < n && i < 11; i++) begin
        expo[en] = src[i] ^ kv(i); en++;
      end
      if (n >= 11) expl[10] = 1'b1;
      e_ok = (n == 13) && use_last && (corrupt == 0);
    end
    clr();
    dir_rx = rx;
    for (int i = 0; i < n; i++) begin
      put(src[i], i == 0, use_last && i == n - 1);
      if (i == 0 && flip_dir) dir_rx = ~rx;
    end
    if (rx) begin
      chk(crc_ok_valid === 1'b1, "R6", {tag, " verdict cycle"}, crc_ok_valid, 1);
    end
    if (!rx && good) begin
      if (junk) begin
        dir_rx = 1'b0; in_data = 8'hFF; in_first = 1'b1; in_last = 1'b1;
      end else in_valid = 1'b0;
      chk(in_ready == 1'b0, "R4", {tag, " stall 1"}, in_ready, 0);
      @(negedge clk);
      chk(in_ready == 1'b0 && out_data == c[15:8], "R4", {tag, " high trailer"},
          out_data, c[15:8]);
      @(negedge clk);
      chk(out_last && crc_ok_valid && crc_ok, "R4", {tag, " low trailer verdict"},
          {out_last, crc_ok_valid, crc_ok}, 3'b111);
      if (junk) begin
        @(negedge clk);
        in_valid = 1'b0;
        expo[en] = 8'h7F; expl[en] = 1'b1; en++;
      end
    end
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    repeat (5) @(negedge clk);
    chk(ocnt == en, rx ? "R5" : "R2", {tag, " byte count"}, ocnt, en);
    for (int i = 0; i < en && i < ocnt; i++) begin
      chk(obuf[i] == expo[i], rx ? "R5" : (i < 14 ? "R2" : "R3"),
          $sformatf("%s byte %0d", tag, i), obuf[i], expo[i]);
      chk(olast[i] == expl[i], rx ? "R5" : "R8",
          $sformatf("%s last flag %0d", tag, i), olast[i], expl[i]);
    end
    chk(okcnt == (junk ? 2 : 1), "R8", {tag, " verdict count"}, okcnt, junk ? 2 : 1);
    if (okcnt > 0)
      chk(okv[0] == e_ok, rx ? (corrupt != 0 ? "R7" : "R6") : "R8",
          {tag, " verdict"}, okv[0], e_ok);
    if (junk && okcnt > 1)
      chk(okv[1] == 1'b0, "R10", {tag, " held byte verdict"}, okv[1], 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    rst_n = 1'b0; dir_rx = 1'b0; in_valid = 1'b0; in_first = 1'b0;
    in_last = 1'b0; in_data = 8'h00;
    ocnt = 0; okcnt = 0; stray_ok = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk(in_ready == 1'b1, "R1", "ready after reset", in_ready, 1);
    chk(!out_valid && !out_last, "R1", "output idle after reset",
        {out_valid, out_last}, 0);
    chk(!crc_ok_valid && !crc_ok, "R1", "verdict idle after reset",
        {crc_ok_valid, crc_ok}, 0);

    // R2 R3 R4: correct transmit frames
    run_frame(1'b0, 14, 1'b1, 0, 1'b0, 1'b0, "tx good a");
    run_frame(1'b0, 14, 1'b1, 0, 1'b0, 1'b0, "tx good b");
    // R10: byte held during the trailer
    run_frame(1'b0, 14, 1'b1, 0, 1'b0, 1'b1, "tx held byte");

    // R5 R6: correct receive frames
    run_frame(1'b1, 13, 1'b1, 0, 1'b0, 1'b0, "rx good a");
    run_frame(1'b1, 13, 1'b1, 0, 1'b0, 1'b0, "rx good b");
    // R7: corrupted receive frames
    run_frame(1'b1, 13, 1'b1, 1, 1'b0, 1'b0, "rx bad high");
    run_frame(1'b1, 13, 1'b1, 2, 1'b0, 1'b0, "rx bad low");
    run_frame(1'b1, 13, 1'b1, 3, 1'b0, 1'b0, "rx bad payload");

    // R8: wrong lengths
    run_frame(1'b0, 5,  1'b1, 0, 1'b0, 1'b0, "tx short");
    run_frame(1'b0, 14, 1'b0, 0, 1'b0, 1'b0, "tx no last");
    run_frame(1'b1, 12, 1'b1, 0, 1'b0, 1'b0, "rx short");
    run_frame(1'b1, 13, 1'b0, 0, 1'b0, 1'b0, "rx no last");
    run_frame(1'b1, 3,  1'b1, 0, 1'b0, 1'b0, "rx tiny");

    // R9: abandoned partial frame, then a restart with direction flipped mid-frame
    clr();
    dir_rx = 1'b0;
    for (int i = 0; i < 5; i++) put(8'(i * 17 + 3), i == 0, 1'b0);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(okcnt == 0, "R9", "no verdict for abandoned frame", okcnt, 0);
    run_frame(1'b1, 13, 1'b1, 0, 1'b1, 1'b0, "rx restart");
    run_frame(1'b0, 14, 1'b1, 0, 1'b1, 1'b0, "tx dir held");

    // random mix
    for (int k = 0; k < 24; k++) begin
      bit rx = 1'($urandom_range(0, 1));
      int sel = $urandom_range(0, 7);
      if (rx)
        run_frame(1'b1, sel == 7 ? 9 : 13, 1'b1, sel > 3 ? sel - 3 : 0, 1'b0, 1'b0, "rx rand");
      else
        run_frame(1'b0, sel == 7 ? 10 : 14, 1'b1, 0, 1'b0, 1'b0, "tx rand");
    end

    chk(!stray_ok, "R11", "verdict bit without strobe", stray_ok, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule